// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a small status byte that tells software which event brought the chip out of its last reset: a low-supply detection, a watchdog expiry, or the external reset pin. Each source delivers a one-cycle pulse. The block latches that pulse into a flag that keeps its value through the system reset that the event itself causes. After restart, firmware reads the byte to learn why the chip restarted.

Firmware reads and clears the flags over a simple register port. The port has an address, a bank select, a write strobe, write data and read data. A flag is cleared by writing 0 to its bit, and writing 1 to a bit leaves it alone. A low-supply event is treated as the most severe cause, so it erases any earlier record.

Two option inputs say whether the low-supply detector and the reset pin are in use. When an option is off, its flag reads as 0.

Top module: `rstcause_reg`

## Requirements
- R1: When the register is selected (address F2h, bank select 1), bit 4 reads the pin flag, bit 2 reads the watchdog flag and bit 1 reads the low-supply flag.
- R2: Bits 7, 6, 5, 3 and 0 always read 0, and data written to them has no effect on any flag.
- R3: After a cycle with `lv_evt` high, the next cycle holds the low-supply flag set and the pin and watchdog flags cleared.
- R4: After a cycle with `wd_evt` or `pin_evt` high and `lv_evt` low, the next cycle holds that source's flag set and leaves every other flag unchanged.
- R5: A selected write clears each flag whose bit position holds 0 in the write data. Flags whose bit holds 1 keep their value.
- R6: If a source event and a selected write of 0 to that same flag occur in one cycle, the flag ends up set.
- R7: If `lv_evt` coincides with `wd_evt` or `pin_evt`, the next cycle holds only the low-supply flag set.
- R8: While `lv_opt_en` is low, bit 1 reads 0. While `pin_opt_en` is low, bit 4 reads 0. The stored flag is kept and shows again once the option returns high.
- R9: A read at any other address or bank returns 0, and a write there changes no flag.
- R10: `por_n` low clears all flags. No other input resets the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| lv_evt | input | 1 | Low-supply reset event pulse |
| wd_evt | input | 1 | Watchdog reset event pulse |
| pin_evt | input | 1 | External pin reset event pulse |
| lv_opt_en | input | 1 | Low-supply detector enabled; low marks bit 1 invalid |
| pin_opt_en | input | 1 | Pin acts as reset input; low marks bit 4 invalid |
| bus_addr | input | ADDR_W | Register address |
| bus_bank | input | 1 | Register bank select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address, bank and options |

## Verification
Event pulses and writes act at the rising edge on which they are present. Their effect is therefore due on `bus_rdata` in the cycle that follows. The bench drives each stimulus at a falling edge and lets one rising edge pass. It then removes the stimulus, sets the read address, and compares the result half a cycle later.

Reads, option masking and address misses are combinational. They are checked in the same cycle the address or option changes, after a short settling delay and with no clock edge in between.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
    localparam int DATA_W  = 8;
    localparam int BIT_LV  = 1;
    localparam int BIT_WD  = 2;
    localparam int BIT_PIN = 4;
    localparam logic [DATA_W-1:0] USED_MASK =
        (DATA_W'(1) << BIT_LV) | (DATA_W'(1) << BIT_WD) | (DATA_W'(1) << BIT_PIN);

    typedef struct packed {
        logic pin;
        logic wd;
        logic lv;
    } cause_t;
endpackage

// File: rtl/rstcause_decode.sv
module rstcause_decode #(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF2,
    parameter logic        REG_BANK = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    input  logic              wr,
    output logic              sel,
    output logic              wr_hit
);
    always_comb begin
        sel    = (addr == REG_ADDR) && (bank == REG_BANK);
        wr_hit = sel && wr;
    end
endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              lv_evt,
    input  logic              wd_evt,
    input  logic              pin_evt,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output cause_t            flags_q
);
    cause_t flags_d;

    always_comb begin
        flags_d = flags_q;
        // software clear first, so a same-cycle event overrides it
        if (clr_en) begin
            if (!wdata[BIT_LV])  flags_d.lv  = 1'b0;
            if (!wdata[BIT_WD])  flags_d.wd  = 1'b0;
            if (!wdata[BIT_PIN]) flags_d.pin = 1'b0;
        end
        if (wd_evt)  flags_d.wd  = 1'b1;
        if (pin_evt) flags_d.pin = 1'b1;
        // low-supply cause dominates and wipes the other records
        if (lv_evt) begin
            flags_d     = '0;
            flags_d.lv  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/rstcause_rdmask.sv
module rstcause_rdmask
    import rstcause_pkg::*;
(
    input  cause_t            flags,
    input  logic              lv_valid,
    input  logic              pin_valid,
    input  logic              sel,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        raw          = '0;
        raw[BIT_LV]  = flags.lv  & lv_valid;
        raw[BIT_WD]  = flags.wd;
        raw[BIT_PIN] = flags.pin & pin_valid;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (USED_MASK[i]) begin : g_used
            assign rdata[i] = sel & raw[i];
        end else begin : g_unused
            assign rdata[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF2,
    parameter logic              REG_BANK = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              lv_evt,
    input  logic              wd_evt,
    input  logic              pin_evt,
    input  logic              lv_opt_en,
    input  logic              pin_opt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_bank,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic   sel;
    logic   wr_hit;
    cause_t flags_q;

    rstcause_decode #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR),
        .REG_BANK(REG_BANK)
    ) u_decode (
        .addr  (bus_addr),
        .bank  (bus_bank),
        .wr    (bus_wr),
        .sel   (sel),
        .wr_hit(wr_hit)
    );

    rstcause_flags u_flags (
        .clk    (clk),
        .por_n  (por_n),
        .lv_evt (lv_evt),
        .wd_evt (wd_evt),
        .pin_evt(pin_evt),
        .clr_en (wr_hit),
        .wdata  (bus_wdata),
        .flags_q(flags_q)
    );

    rstcause_rdmask u_rdmask (
        .flags    (flags_q),
        .lv_valid (lv_opt_en),
        .pin_valid(pin_opt_en),
        .sel      (sel),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/rstcause_reg_chk.sv
module rstcause_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF2,
    parameter logic              REG_BANK = 1'b1
) (
    input logic              clk,
    input logic              por_n,
    input logic              lv_evt,
    input logic              wd_evt,
    input logic              pin_evt,
    input logic              lv_opt_en,
    input logic              pin_opt_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_bank,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [2:0]        flags_q
);
    logic hit_sel, hit_wr, any_evt;
    assign hit_sel = (bus_addr == REG_ADDR) && (bus_bank == REG_BANK);
    assign hit_wr  = hit_sel && bus_wr;
    assign any_evt = lv_evt || wd_evt || pin_evt;

    a_r3_lv_only: assert property (@(posedge clk) disable iff (!por_n)
        lv_evt |=> (flags_q == 3'b001));
    a_r7_lv_dominates: assert property (@(posedge clk) disable iff (!por_n)
        (lv_evt && (wd_evt || pin_evt)) |=> (flags_q == 3'b001));
    a_r4_wd_sets: assert property (@(posedge clk) disable iff (!por_n)
        (wd_evt && !lv_evt) |=> flags_q[1]);
    a_r4_pin_sets: assert property (@(posedge clk) disable iff (!por_n)
        (pin_evt && !lv_evt) |=> flags_q[2]);
    a_r4_lv_kept: assert property (@(posedge clk) disable iff (!por_n)
        (!lv_evt && (wd_evt || pin_evt) && !hit_wr) |=> $stable(flags_q[0]));
    a_r5_ones_keep: assert property (@(posedge clk) disable iff (!por_n)
        (hit_wr && bus_wdata == 8'hFF && !any_evt) |=> $stable(flags_q));
    a_r5_zeros_clear: assert property (@(posedge clk) disable iff (!por_n)
        (hit_wr && bus_wdata == 8'h00 && !any_evt) |=> (flags_q == 3'b000));
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        (hit_wr && !bus_wdata[2] && wd_evt && !lv_evt) |=> flags_q[1]);
    a_r9_miss_nowrite: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && !hit_sel && !any_evt) |=> $stable(flags_q));
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata & 8'hE9) == 8'h00);
    a_r8_lv_invalid: assert property (@(posedge clk) disable iff (!por_n)
        !lv_opt_en |-> !bus_rdata[1]);
    a_r8_pin_invalid: assert property (@(posedge clk) disable iff (!por_n)
        !pin_opt_en |-> !bus_rdata[4]);
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
        !hit_sel |-> (bus_rdata == 8'h00));
endmodule

bind rstcause_reg rstcause_reg_chk #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .REG_BANK(REG_BANK)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .lv_evt    (lv_evt),
    .wd_evt    (wd_evt),
    .pin_evt   (pin_evt),
    .lv_opt_en (lv_opt_en),
    .pin_opt_en(pin_opt_en),
    .bus_addr  (bus_addr),
    .bus_bank  (bus_bank),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags_q   (flags_q)
);

// File: tb/rstcause_reg_tb.sv
module rstcause_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [3:0] req;
        logic       lv;
        logic       wd;
        logic       pin;
        logic       wr;
        logic       bank;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       lvo;
        logic       pino;
        logic [7:0] exp;
    } vec_t;

    // fields: req, lv, wd, pin, wr, bank, addr, wdata, lv_opt, pin_opt, expected read
    localparam logic [34:0] VECS [0:NVEC-1] = '{
        {4'd4,  1'b0,1'b1,1'b0, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h04}, // R4 watchdog
        {4'd4,  1'b0,1'b0,1'b1, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h14}, // R4 pin keeps wd
        {4'd5,  1'b0,1'b0,1'b0, 1'b1,1'b1,8'hF2,8'hFF, 1'b1,1'b1, 8'h14}, // R5 ones no effect
        {4'd5,  1'b0,1'b0,1'b0, 1'b1,1'b1,8'hF2,8'hEF, 1'b1,1'b1, 8'h04}, // R5 clear pin
        {4'd3,  1'b1,1'b0,1'b0, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h02}, // R3 lv wipes
        {4'd4,  1'b0,1'b1,1'b1, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h16}, // R4 keeps lv
        {4'd7,  1'b1,1'b1,1'b1, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h02}, // R7 lv dominates
        {4'd8,  1'b0,1'b0,1'b1, 1'b0,1'b1,8'hF2,8'h00, 1'b0,1'b1, 8'h10}, // R8 lv masked
        {4'd8,  1'b0,1'b0,1'b0, 1'b0,1'b1,8'hF2,8'h00, 1'b1,1'b0, 8'h02}, // R8 pin masked
        {4'd6,  1'b0,1'b1,1'b0, 1'b1,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h04}, // R6 set beats clear
        {4'd9,  1'b0,1'b0,1'b0, 1'b1,1'b0,8'hF2,8'h00, 1'b1,1'b1, 8'h04}, // R9 wrong bank
        {4'd9,  1'b0,1'b0,1'b0, 1'b1,1'b1,8'hF3,8'h00, 1'b1,1'b1, 8'h04}, // R9 wrong address
        {4'd2,  1'b0,1'b0,1'b0, 1'b1,1'b1,8'hF2,8'hEC, 1'b1,1'b1, 8'h04}, // R2 unused bits written
        {4'd5,  1'b0,1'b0,1'b0, 1'b1,1'b1,8'hF2,8'h00, 1'b1,1'b1, 8'h00}  // R5 clear all
    };

    logic       clk = 1'b0;
    logic       por_n;
    logic       lv_evt, wd_evt, pin_evt, lv_opt_en, pin_opt_en;
    logic [7:0] bus_addr;
    logic       bus_bank, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstcause_reg u_dut (
        .clk(clk), .por_n(por_n), .lv_evt(lv_evt), .wd_evt(wd_evt), .pin_evt(pin_evt),
        .lv_opt_en(lv_opt_en), .pin_opt_en(pin_opt_en), .bus_addr(bus_addr),
        .bus_bank(bus_bank), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: read %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle_read();
        lv_evt = 0; wd_evt = 0; pin_evt = 0; bus_wr = 0; bus_wdata = 8'h00;
        bus_addr = 8'hF2; bus_bank = 1'b1;
    endtask

    task automatic pulse(input logic l, input logic w, input logic p);
        @(negedge clk);
        lv_evt = l; wd_evt = w; pin_evt = p;
        @(posedge clk);
        @(negedge clk);
        idle_read();
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: run hung, read %02h expected progress", bus_rdata);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        por_n = 1'b0; lv_opt_en = 1'b1; pin_opt_en = 1'b1;
        idle_read();
        #(CLK_PERIOD * 3 + 2);
        check("R10 reset state", bus_rdata, 8'h00);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk); #1;
        check("R10 after release", bus_rdata, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            v = vec_t'(VECS[i]);
            @(negedge clk);
            lv_evt = v.lv; wd_evt = v.wd; pin_evt = v.pin;
            bus_wr = v.wr; bus_bank = v.bank; bus_addr = v.addr; bus_wdata = v.wdata;
            lv_opt_en = v.lvo; pin_opt_en = v.pino;
            @(posedge clk);
            @(negedge clk);
            idle_read();
            #1;
            check($sformatf("R%0d vector %0d", v.req, i), bus_rdata, v.exp);
        end

        // R1: each flag lands on its own bit position
        pulse(1'b1, 1'b0, 1'b0);
        check("R1 lv on bit 1", bus_rdata, 8'h02);
        pulse(1'b0, 1'b1, 1'b1);
        check("R1 all on bits 4,2,1", bus_rdata, 8'h16);
        check("R2 unused bits zero", bus_rdata & 8'hE9, 8'h00);

        // R9: miss reads zero while flags are set
        bus_addr = 8'h72; #1;
        check("R9 other address reads zero", bus_rdata, 8'h00);
        bus_addr = 8'hF2; bus_bank = 1'b0; #1;
        check("R9 other bank reads zero", bus_rdata, 8'h00);
        bus_bank = 1'b1; #1;

        // R8: storage kept while masked
        lv_opt_en = 1'b0; pin_opt_en = 1'b0; #1;
        check("R8 both masked", bus_rdata, 8'h04);
        lv_opt_en = 1'b1; pin_opt_en = 1'b1; #1;
        check("R8 restored", bus_rdata, 8'h16);

        // R6: pin event with a clear of the pin bit in one cycle
        @(negedge clk);
        pin_evt = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
        @(posedge clk); @(negedge clk); idle_read(); #1;
        check("R6 pin set beats clear", bus_rdata, 8'h10);

        // R10: power-on reset mid-run clears
        @(negedge clk); por_n = 1'b0; #1;
        check("R10 por clears", bus_rdata, 8'h00);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk); #1;
        check("R10 stays clear", bus_rdata, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule